// File: doc/BRIEF.md
# Receive-Threshold DMA Bus Arbiter

This block decides which of two DMA engines in a 10/100 Ethernet MAC, transmit or receive, owns the shared bus master next. It also decides how many beats the owner may move in the burst it is granted. Once a grant is issued it stays in place until the bus side reports that the transfer is done, so a burst in flight is never taken away.

With threshold arbitration turned on, receive priority follows the fill level of the receive FIFO with hysteresis. The two marks are programmed as eighths of the FIFO depth. Priority switches on when the level climbs to the upper mark and switches off once the level has drained to the lower mark. With threshold arbitration turned off, contested requests alternate between the two engines.

Burst length comes from three capability enables (4, 8 and 16 beats) and a maximum-burst selector. The block picks the largest enabled size that fits both the words the requester still has to move and the selected ceiling. If no size fits, it falls back to a single beat.

Top module: `dma_thr_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `grant_tx`, `grant_rx` and `burst_len` are all 0. `burst_len` reads 0 in every cycle in which neither grant is high.
- R2: At most one grant is high at a time. A grant, together with its `burst_len`, stays unchanged in every cycle until `xfer_done` is seen high at a clock edge.
- R3: With no grant held, a clock edge that sees at least one request raises exactly one grant in the next cycle. If only one engine is requesting, that engine gets the grant.
- R4: With `thr_en`=1, the receive-urgent state is set at a clock edge where `rx_level` >= `thr_high`*DEPTH/8.
- R5: With `thr_en`=1, the urgent state is cleared at an edge where `rx_level` <= `thr_low`*DEPTH/8 and the level is below the upper mark. Between the marks it keeps its value. With `thr_en`=0 it is cleared.
- R6: With `thr_en`=1 and both engines requesting while idle, receive wins if the urgent state (as held before that edge) is set. Otherwise transmit wins.
- R7: With `thr_en`=0 and both engines requesting while idle, the winner is the engine that did not receive the previous grant. After reset, receive wins first.
- R8: `burst_len` is set when the grant is issued. It is the largest of 16, 8 and 4 whose enable bit (`burst_cap` bit 2, 1 and 0 respectively) is set and which is <= min(remaining words of the winner, ceiling). If none qualifies, it is 1.
- R9: The `burst_max_sel` ceiling encoding is: 0 = no ceiling, 1 = 8 words, 2 = 32 words, 3 = 64 words.
- R10: A clock edge that sees `xfer_done` high while a grant is held drops both grants in the next cycle. That cycle is always idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_req | input | 1 | Transmit DMA requests the bus |
| rx_req | input | 1 | Receive DMA requests the bus |
| tx_remain | input | LEN_W | Words left in the transmit transfer |
| rx_remain | input | LEN_W | Words left in the receive transfer |
| rx_level | input | LVL_W | Receive FIFO fill level in words (0..DEPTH) |
| thr_en | input | 1 | Enable threshold arbitration |
| thr_high | input | 3 | Upper mark in eighths of the FIFO depth |
| thr_low | input | 3 | Lower mark in eighths of the FIFO depth |
| burst_max_sel | input | 2 | Burst ceiling selector |
| burst_cap | input | 3 | Burst enables: bit0 = 4, bit1 = 8, bit2 = 16 beats |
| xfer_done | input | 1 | Current granted burst is finished |
| grant_tx | output | 1 | Bus granted to transmit DMA |
| grant_rx | output | 1 | Bus granted to receive DMA |
| burst_len | output | 5 | Beats allowed in the granted burst (0 when idle) |

## Verification
Directed sequences walk `rx_level` up to one step below the upper mark, onto the mark, back into the window and onto the lower mark, with both engines requesting each time. The winner at each step shows whether set, hold and clear happen at the right thresholds. With thresholds off, repeated contested requests show alternation rather than fixed priority. Burst checks combine long, mid-size and short remainders with each ceiling and with sparse capability sets, which separates a ceiling bug from a capability or remainder bug. A long random phase holds grants over random `xfer_done` gaps while requests and control fields keep changing, which exposes preemption and stale burst lengths.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    // Number of burst capability enables: sizes 4, 8 and 16 beats
    localparam int CAP_N   = 3;
    localparam int BURST_W = 5;

    // Ceiling selector encoding
    typedef enum logic [1:0] {
        BMAX_NONE = 2'd0,
        BMAX_8    = 2'd1,
        BMAX_32   = 2'd2,
        BMAX_64   = 2'd3
    } bmax_e;

    // Beats of capability i: 4 << i
    function automatic int cap_size(input int i);
        return 4 << i;
    endfunction

    // Ceiling in words for a given selector (NONE handled by caller)
    function automatic int bmax_words(input bmax_e sel);
        case (sel)
            BMAX_8:  return 8;
            BMAX_32: return 32;
            BMAX_64: return 64;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/dma_rx_hyst.sv
// Receive-urgent hysteresis tracker.
// Converts the 3-bit eighth-of-depth marks to word counts and keeps one
// state bit: set at or above the upper mark, cleared at or below the lower
// mark, held in between. Assumes rx_level never exceeds FIFO_DEPTH.
// If the marks overlap, setting wins.
module dma_rx_hyst #(
    parameter int FIFO_DEPTH = 64,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_en,
    input  logic [2:0]       thr_high,
    input  logic [2:0]       thr_low,
    input  logic [LVL_W-1:0] rx_level,
    output logic             urgent
);
    localparam int MARK_W = LVL_W + 3;

    logic [MARK_W-1:0] hi_mark;
    logic [MARK_W-1:0] lo_mark;
    logic [MARK_W-1:0] lvl_ext;
    logic              at_hi;
    logic              at_lo;

    // Mark conversion: n/8 of the FIFO depth, rounded down
    always_comb begin
        hi_mark = (MARK_W'(thr_high) * MARK_W'(FIFO_DEPTH)) >> 3;
        lo_mark = (MARK_W'(thr_low) * MARK_W'(FIFO_DEPTH)) >> 3;
        lvl_ext = MARK_W'(rx_level);
        at_hi   = (lvl_ext >= hi_mark);
        at_lo   = (lvl_ext <= lo_mark);
    end

    // Urgent state register with set priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            urgent <= 1'b0;
        end else if (!thr_en) begin
            urgent <= 1'b0;
        end else if (at_hi) begin
            urgent <= 1'b1;
        end else if (at_lo) begin
            urgent <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_burst_sizer.sv
// Burst size selection for one requester (combinational).
// Clamps the remaining words to the selected ceiling, then picks the
// largest enabled capability that fits. Falls back to one beat.
// Assumes LEN_W is wide enough to hold the largest ceiling (64).
module dma_burst_sizer #(
    parameter int LEN_W = 11
) (
    input  logic [LEN_W-1:0]                 remain,
    input  logic [dma_arb_pkg::CAP_N-1:0]    cap,
    input  logic [1:0]                       max_sel,
    output logic [dma_arb_pkg::BURST_W-1:0]  beats
);
    import dma_arb_pkg::*;

    logic [LEN_W-1:0] limit;
    logic [LEN_W-1:0] chunk;
    logic [CAP_N-1:0] fits;

    // Ceiling lookup and clamp of the remaining words
    always_comb begin
        if (bmax_e'(max_sel) == BMAX_NONE) begin
            limit = remain;
        end else begin
            limit = LEN_W'(bmax_words(bmax_e'(max_sel)));
        end
        chunk = (limit < remain) ? limit : remain;
    end

    // One fit flag per capability size
    for (genvar gi = 0; gi < CAP_N; gi++) begin : g_fit
        assign fits[gi] = cap[gi] && (LEN_W'(cap_size(gi)) <= chunk);
    end

    // Largest fitting size wins; single beat otherwise
    always_comb begin
        beats = BURST_W'(1);
        for (int i = 0; i < CAP_N; i++) begin
            if (fits[i]) begin
                beats = BURST_W'(cap_size(i));
            end
        end
    end

endmodule

// File: rtl/dma_arb_core.sv
// Grant state machine for the two DMA engines.
// Idle: picks a winner from the requests, by urgency when thresholds are
// enabled and by alternation when not, and latches that winner's burst.
// Busy: holds grant and burst until done. Assumes done is only meaningful
// while a grant is held.
module dma_arb_core (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             tx_req,
    input  logic                             rx_req,
    input  logic                             thr_en,
    input  logic                             urgent,
    input  logic                             done,
    input  logic [dma_arb_pkg::BURST_W-1:0]  tx_beats,
    input  logic [dma_arb_pkg::BURST_W-1:0]  rx_beats,
    output logic                             grant_tx,
    output logic                             grant_rx,
    output logic [dma_arb_pkg::BURST_W-1:0]  burst_len
);
    import dma_arb_pkg::*;

    logic gt_q, gr_q, last_rx_q;
    logic [BURST_W-1:0] blen_q;
    logic idle;
    logic pick_rx;

    // Winner selection for the next grant
    always_comb begin
        idle = !gt_q && !gr_q;
        if (tx_req && rx_req) begin
            pick_rx = thr_en ? urgent : !last_rx_q;
        end else begin
            pick_rx = rx_req;
        end
    end

    // Grant, burst and alternation state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gt_q      <= 1'b0;
            gr_q      <= 1'b0;
            blen_q    <= '0;
            last_rx_q <= 1'b0;
        end else if (!idle) begin
            if (done) begin
                gt_q   <= 1'b0;
                gr_q   <= 1'b0;
                blen_q <= '0;
            end
        end else if (tx_req || rx_req) begin
            gt_q      <= !pick_rx;
            gr_q      <= pick_rx;
            blen_q    <= pick_rx ? rx_beats : tx_beats;
            last_rx_q <= pick_rx;
        end
    end

    assign grant_tx  = gt_q;
    assign grant_rx  = gr_q;
    assign burst_len = blen_q;

endmodule

// File: rtl/dma_thr_arbiter.sv
// Top level: transmit/receive DMA bus arbiter with receive-threshold
// priority and capability-based burst sizing.
// Assumes requests stay up until granted and xfer_done pulses once per
// granted burst. The bus protocol itself lives outside this block.
module dma_thr_arbiter #(
    parameter int FIFO_DEPTH = 64,
    parameter int LEN_W      = 11,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             tx_req,
    input  logic                             rx_req,
    input  logic [LEN_W-1:0]                 tx_remain,
    input  logic [LEN_W-1:0]                 rx_remain,
    input  logic [LVL_W-1:0]                 rx_level,
    input  logic                             thr_en,
    input  logic [2:0]                       thr_high,
    input  logic [2:0]                       thr_low,
    input  logic [1:0]                       burst_max_sel,
    input  logic [2:0]                       burst_cap,
    input  logic                             xfer_done,
    output logic                             grant_tx,
    output logic                             grant_rx,
    output logic [4:0]                       burst_len
);
    import dma_arb_pkg::*;

    logic               urgent;
    logic [BURST_W-1:0] beats [2];
    logic [LEN_W-1:0]   remain [2];

    assign remain[0] = tx_remain;
    assign remain[1] = rx_remain;

    dma_rx_hyst #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .LVL_W      (LVL_W)
    ) u_hyst (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_en   (thr_en),
        .thr_high (thr_high),
        .thr_low  (thr_low),
        .rx_level (rx_level),
        .urgent   (urgent)
    );

    // One burst sizer per engine: index 0 transmit, 1 receive
    for (genvar gs = 0; gs < 2; gs++) begin : g_sizer
        dma_burst_sizer #(
            .LEN_W (LEN_W)
        ) u_sizer (
            .remain  (remain[gs]),
            .cap     (burst_cap),
            .max_sel (burst_max_sel),
            .beats   (beats[gs])
        );
    end

    dma_arb_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_req    (tx_req),
        .rx_req    (rx_req),
        .thr_en    (thr_en),
        .urgent    (urgent),
        .done      (xfer_done),
        .tx_beats  (beats[0]),
        .rx_beats  (beats[1]),
        .grant_tx  (grant_tx),
        .grant_rx  (grant_rx),
        .burst_len (burst_len)
    );

endmodule

// File: rtl/dma_thr_arbiter_chk.sv
// Assertion checker for dma_thr_arbiter, attached by bind below.
module dma_thr_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_req,
    input logic       rx_req,
    input logic       xfer_done,
    input logic       grant_tx,
    input logic       grant_rx,
    input logic [4:0] burst_len
);
    logic busy;
    assign busy = grant_tx || grant_rx;

    p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_tx, grant_rx}));

    p_hold_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_tx && !xfer_done) |=> (grant_tx && $stable(burst_len)));

    p_hold_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_rx && !xfer_done) |=> (grant_rx && $stable(burst_len)));

    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_done) |=> !busy);

    p_grant_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (tx_req || rx_req)) |=> busy);

    p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !tx_req && !rx_req) |=> !busy);

    p_idle_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (burst_len == 5'd0));

    p_legal_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (burst_len == 5'd1 || burst_len == 5'd4 ||
                  burst_len == 5'd8 || burst_len == 5'd16));

endmodule

bind dma_thr_arbiter dma_thr_arbiter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_req    (tx_req),
    .rx_req    (rx_req),
    .xfer_done (xfer_done),
    .grant_tx  (grant_tx),
    .grant_rx  (grant_rx),
    .burst_len (burst_len)
);

// File: tb/test_dma_thr_arbiter.sv
module test_dma_thr_arbiter;
    localparam int DEPTH = 64;
    localparam int LW    = 11;
    localparam int VW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_req = 0, rx_req = 0, thr_en = 1, xfer_done = 0;
    logic [LW-1:0] tx_remain = 0, rx_remain = 0;
    logic [VW-1:0] rx_level = 0;
    logic [2:0]    thr_high = 3'd6, thr_low = 3'd2, burst_cap = 3'b111;
    logic [1:0]    burst_max_sel = 0;
    logic          grant_tx, grant_rx;
    logic [4:0]    burst_len;

    int    n_chk = 0, n_err = 0;
    bit    finished = 0;
    string tag = "R1";

    // reference state
    logic       m_gt = 0, m_gr = 0, m_urg = 0, m_last = 0;
    logic [4:0] m_len = 0;

    always #2.5 clk = ~clk;

    dma_thr_arbiter #(.FIFO_DEPTH(DEPTH), .LEN_W(LW)) i_dma_thr_arbiter (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .rx_req(rx_req),
        .tx_remain(tx_remain), .rx_remain(rx_remain), .rx_level(rx_level),
        .thr_en(thr_en), .thr_high(thr_high), .thr_low(thr_low),
        .burst_max_sel(burst_max_sel), .burst_cap(burst_cap),
        .xfer_done(xfer_done), .grant_tx(grant_tx), .grant_rx(grant_rx),
        .burst_len(burst_len));

    // Expected burst from R8/R9
    function automatic logic [4:0] exp_burst(input int rem, input logic [2:0] cap,
                                             input logic [1:0] sel);
        int lim, ch;
        lim = (sel == 0) ? 32'h7fffffff : (sel == 1) ? 8 : (sel == 2) ? 32 : 64;
        ch  = (rem < lim) ? rem : lim;
        if (cap[2] && ch >= 16) return 5'd16;
        if (cap[1] && ch >= 8)  return 5'd8;
        if (cap[0] && ch >= 4)  return 5'd4;
        return 5'd1;
    endfunction

    // Reference model, stepped from the requirements each edge
    always @(posedge clk) begin
        logic pr;
        if (!rst_n) begin
            m_gt <= 0; m_gr <= 0; m_urg <= 0; m_last <= 0; m_len <= 0;
        end else begin
            if (!thr_en) m_urg <= 0;
            else if (int'(rx_level) >= int'(thr_high) * DEPTH / 8) m_urg <= 1;
            else if (int'(rx_level) <= int'(thr_low) * DEPTH / 8) m_urg <= 0;
            if (m_gt || m_gr) begin
                if (xfer_done) begin m_gt <= 0; m_gr <= 0; m_len <= 0; end
            end else if (tx_req || rx_req) begin
                pr = (tx_req && rx_req) ? (thr_en ? m_urg : !m_last) : rx_req;
                m_gr <= pr; m_gt <= !pr; m_last <= pr;
                m_len <= pr ? exp_burst(int'(rx_remain), burst_cap, burst_max_sel)
                            : exp_burst(int'(tx_remain), burst_cap, burst_max_sel);
            end
        end
    end

    task automatic compare();
        n_chk++;
        if (grant_tx !== m_gt || grant_rx !== m_gr || burst_len !== m_len) begin
            n_err++;
            $display("FAIL %s: got tx=%0b rx=%0b len=%0d exp tx=%0b rx=%0b len=%0d",
                     tag, grant_tx, grant_rx, burst_len, m_gt, m_gr, m_len);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
        end
    endtask

    // Contest from idle: both request, one edge to grant, then release
    task automatic contest(input string t);
        tag = t;
        tx_req = 1; rx_req = 1; xfer_done = 0;
        step(1);
        tx_req = 0; rx_req = 0; xfer_done = 1;
        step(1);
        xfer_done = 0;
        step(1);
    endtask

    task automatic one_grant(input string t, input bit use_rx, input int rem);
        tag = t;
        if (use_rx) begin rx_req = 1; rx_remain = LW'(rem); end
        else begin tx_req = 1; tx_remain = LW'(rem); end
        step(1);
        tx_req = 0; rx_req = 0; xfer_done = 1;
        step(1);
        xfer_done = 0;
    endtask

    task automatic finish_up();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        tag = "R1";
        step(3);
        rst_n = 1;
        step(2);

        // R3, R8: single requester, unlimited ceiling
        one_grant("R3", 0, 100);
        one_grant("R8", 1, 100);

        // R2: hold with competing request, no done
        tag = "R2";
        tx_req = 1; tx_remain = 12;
        step(1);
        rx_req = 1;
        step(5);
        tag = "R10";
        xfer_done = 1; tx_req = 0; rx_req = 0;
        step(1);
        xfer_done = 0;
        step(2);

        // R4/R5/R6: hysteresis with marks 48 and 16
        thr_en = 1; thr_high = 6; thr_low = 2;
        rx_level = 47; step(2); contest("R6");
        rx_level = 48; step(2); contest("R4");
        rx_level = 20; step(2); contest("R5");
        rx_level = 16; step(2); contest("R5");
        rx_level = 40; step(2); contest("R5");
        thr_high = 0; rx_level = 0; step(2); contest("R4");

        // R7: alternation with thresholds off
        thr_en = 0; thr_high = 6; rx_level = 64;
        step(2);
        for (int k = 0; k < 4; k++) contest("R7");

        // R8/R9: burst sizing corners
        burst_cap = 3'b111; burst_max_sel = 1; one_grant("R9", 0, 100);
        burst_max_sel = 2; one_grant("R9", 1, 100);
        burst_max_sel = 3; one_grant("R9", 0, 30);
        burst_max_sel = 0; one_grant("R8", 0, 5);
        burst_cap = 3'b000; one_grant("R8", 1, 100);
        burst_cap = 3'b010; one_grant("R8", 0, 7);
        burst_cap = 3'b101; one_grant("R8", 1, 15);
        burst_cap = 3'b111; one_grant("R8", 0, 0);
        burst_max_sel = 1; burst_cap = 3'b100; one_grant("R9", 1, 100);

        // Random phase: grants held over random done gaps
        tag = "R2";
        for (int k = 0; k < 4000; k++) begin
            tx_req = ($urandom % 3) != 0;
            rx_req = ($urandom % 3) != 0;
            xfer_done = ($urandom % 4) == 0;
            rx_level = VW'($urandom % (DEPTH + 1));
            tx_remain = LW'($urandom % 200);
            rx_remain = LW'($urandom % 200);
            if ($urandom % 50 == 0) begin
                thr_en = $urandom; thr_high = $urandom; thr_low = $urandom;
                burst_cap = $urandom; burst_max_sel = $urandom;
            end
            if ($urandom % 500 == 0) begin
                tag = "R1"; rst_n = 0; step(1); rst_n = 1; tag = "R2";
            end
            step(1);
        end
        finish_up();
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_up();
        end
    end
endmodule